// File: doc/BRIEF.md
# Host-to-Register-Bus Bridge

This block sits behind a 64-bit host load/store window and turns each access into a transaction on a narrow internal register bus. The window spans 2^OFF_W bytes, by default 0x8_0000_0000. A chip's window begins at 0x3fc0000000000 plus the chip index times that size, and the host decoder is expected to route such addresses here. Registers are 64-bit words at 8-byte spacing, so the register address is the window offset shifted right by three.

A small group of addresses is answered inside the bridge without touching the bus. One is a read-only identity word. Others read as zero or swallow writes. All other 8-byte accesses go out over a single-outstanding request/acknowledge handshake, and the host is held until that handshake completes or a timeout expires. The outcome is never reported as a bus error. Instead, every access ORs a done flag, and on failure also a fail flag, into a sticky status pair that only reset or a clear input resets. Data crosses in big-endian order: host byte lane 0 carries the most significant byte of the register value.

Top module: `regbus_bridge`

## Requirements
- R1: A forwarded access drives `rb_addr` with `host_off >> 3`. The offset's top bit lands in `rb_addr[31]`.
- R2: An access whose `host_size` is not 8 never reaches the bus. It completes with both `status_done` and `status_fail` set, and a read returns zero.
- R3: A read of register 0x000F000F returns the `CHIP_ID` parameter without a bus transfer. A write there is dropped and leaves the identity unchanged.
- R4: The following reads return zero and are not forwarded: 0x01010C00, 0x01010C03, 0x02020007, 0x02020009, 0x0202000F and 0x02013F00..0x02013F07. Neighbours such as 0x01010C01 and 0x02013F08 are forwarded.
- R5: Writes to 0x01010C00..0x01010C05, 0x02020007, 0x02020009 and 0x0202000F are discarded without a bus transfer. A write to 0x01010C06 is forwarded.
- R6: Every completed access, whether local or forwarded, sets `status_done`. A forwarded access acknowledged without error leaves `status_fail` untouched.
- R7: A forwarded access acknowledged with `rb_err` high sets both `status_fail` and `status_done`, and a read returns zero.
- R8: If `rb_ack` does not arrive while `rb_req` has been high for TIMEOUT cycles, `rb_req` drops and the access completes as a failure with read data zero. Latencies below that limit complete normally.
- R9: `status_done` and `status_fail` are sticky. Only reset or `clr_status` clears them. When a completion and `clr_status` fall in the same cycle, the completion's flags are kept.
- R10: Byte lane k of host data (bits 8k+7:8k) maps to byte 7-k of the register value, in both directions.
- R11: `rb_req` stays high with a stable address until `rb_ack` or timeout and then drops for at least one cycle. `host_ack` is a one-cycle pulse and carries the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | OFF_W | Byte offset inside the bridge window |
| host_size | input | 4 | Access size in bytes |
| host_wdata | input | 64 | Host write data, byte lane 0 in bits 7:0 |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 64 | Host read data, valid with `host_ack` |
| clr_status | input | 1 | Clears the sticky status flags |
| status_done | output | 1 | Sticky access-completed flag |
| status_fail | output | 1 | Sticky access-failed flag |
| rb_req | output | 1 | Register bus request |
| rb_we | output | 1 | Register bus write strobe |
| rb_addr | output | OFF_W-3 | Register bus address |
| rb_wdata | output | 64 | Register bus write data |
| rb_ack | input | 1 | Register bus acknowledge |
| rb_err | input | 1 | Register bus error, valid with `rb_ack` |
| rb_rdata | input | 64 | Register bus read data, valid with `rb_ack` |

## Verification
On every cycle the assertions check the following:
- the request/acknowledge discipline;
- that no request outlives the timeout window;
- that fail never appears without done;
- that the status flags hold until cleared;
- that each completion pulse comes with done set.

The address decode has to be shown by the bench's scenarios. This covers which addresses stay local, the read-versus-write asymmetry of the intercepts, byte reordering, the translated address and the data returned. The bench compares bus traffic counts and returned words against its own model across directed boundary addresses and a seeded random mix.

// File: rtl/regbus_bridge.sv
module regbus_bridge #(
  parameter logic [63:0] CHIP_ID = 64'h1A2B_3C4D_0000_0001,
  parameter int OFF_W   = 35,
  parameter int TIMEOUT = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [OFF_W-1:0]  host_off,
  input  logic [3:0]        host_size,
  input  logic [63:0]       host_wdata,
  output logic              host_ack,
  output logic [63:0]       host_rdata,
  input  logic              clr_status,
  output logic              status_done,
  output logic              status_fail,
  output logic              rb_req,
  output logic              rb_we,
  output logic [OFF_W-4:0]  rb_addr,
  output logic [63:0]       rb_wdata,
  input  logic              rb_ack,
  input  logic              rb_err,
  input  logic [63:0]       rb_rdata
);
  localparam int RA_W  = OFF_W - 3;
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  function automatic logic [63:0] bswap(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic logic hit(input logic [RA_W-1:0] a, input logic [31:0] c);
    return a == RA_W'(c);
  endfunction

  logic [RA_W-1:0]  ra;
  logic             size_ok, is_id, rd_zero, wr_drop, local_hit;
  logic             busy, accept, bus_done, bus_to, fin, fin_fail;
  logic [CNT_W-1:0] cnt;

  assign ra      = host_off[OFF_W-1:3];
  assign size_ok = host_size == 4'd8;
  assign is_id   = hit(ra, 32'h000F_000F);
  assign rd_zero = hit(ra, 32'h0101_0C00) || hit(ra, 32'h0101_0C03) ||
                   hit(ra, 32'h0202_0007) || hit(ra, 32'h0202_0009) ||
                   hit(ra, 32'h0202_000F) ||
                   (ra[RA_W-1:3] == (RA_W-3)'(32'h0201_3F00 >> 3));
  assign wr_drop = is_id ||
                   (ra >= RA_W'(32'h0101_0C00) && ra <= RA_W'(32'h0101_0C05)) ||
                   hit(ra, 32'h0202_0007) || hit(ra, 32'h0202_0009) ||
                   hit(ra, 32'h0202_000F);

  assign local_hit = !size_ok || (host_we ? wr_drop : (is_id || rd_zero));
  assign accept    = host_req && !host_ack && !busy;
  assign bus_done  = busy && rb_ack;
  assign bus_to    = busy && !rb_ack && cnt == CNT_W'(TIMEOUT - 1);
  assign fin       = (accept && local_hit) || bus_done || bus_to;
  assign fin_fail  = accept ? !size_ok : (bus_to || (bus_done && rb_err));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt         <= '0;
      host_ack    <= 1'b0;
      host_rdata  <= '0;
      status_done <= 1'b0;
      status_fail <= 1'b0;
      rb_req      <= 1'b0;
      rb_we       <= 1'b0;
      rb_addr     <= '0;
      rb_wdata    <= '0;
    end else begin
      host_ack    <= fin;
      status_done <= (status_done && !clr_status) || fin;
      status_fail <= (status_fail && !clr_status) || (fin && fin_fail);

      if (accept && local_hit)
        host_rdata <= (size_ok && !host_we && is_id) ? bswap(CHIP_ID) : '0;
      else if (bus_done)
        host_rdata <= (rb_err || rb_we) ? '0 : bswap(rb_rdata);
      else if (bus_to)
        host_rdata <= '0;

      if (accept && !local_hit) begin
        busy     <= 1'b1;
        cnt      <= '0;
        rb_req   <= 1'b1;
        rb_we    <= host_we;
        rb_addr  <= ra;
        rb_wdata <= bswap(host_wdata);
      end else if (bus_done || bus_to) begin
        busy   <= 1'b0;
        rb_req <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module regbus_bridge_chk #(
  parameter int OFF_W   = 35,
  parameter int TIMEOUT = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_ack,
  input logic             clr_status,
  input logic             status_done,
  input logic             status_fail,
  input logic             rb_req,
  input logic             rb_ack,
  input logic [OFF_W-4:0] rb_addr
);
  localparam int RUN_W = $clog2(TIMEOUT + 2);
  logic [RUN_W-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (!rb_req) run <= '0;
    else if (run <= RUN_W'(TIMEOUT)) run <= run + 1'b1;
  end

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) status_fail |-> status_done); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) status_done && !clr_status |=> status_done); // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) status_fail && !clr_status |=> status_fail); // R9
  AST_ACK_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n) host_ack |-> status_done); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) host_ack |=> !host_ack); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) rb_req && !rb_ack && run < RUN_W'(TIMEOUT - 1) |=> rb_req && $stable(rb_addr)); // R11
  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) rb_req && rb_ack |=> !rb_req && host_ack); // R11
  AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) rb_req |-> run < RUN_W'(TIMEOUT)); // R8
endmodule

bind regbus_bridge regbus_bridge_chk #(.OFF_W(OFF_W), .TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/test_regbus_bridge.sv
module test_regbus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] ID = 64'h1A2B_3C4D_0000_0001;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0, clr_status = 0;
  logic [34:0] host_off = '0;
  logic [3:0]  host_size = 4'd8;
  logic [63:0] host_wdata = '0;
  logic host_ack, status_done, status_fail, rb_req, rb_we;
  logic [63:0] host_rdata, rb_wdata;
  logic [31:0] rb_addr;
  logic rb_ack = 0, rb_err = 0;
  logic [63:0] rb_rdata = '0;

  int unsigned checks = 0, fails = 0, bus_cnt = 0, starts = 0;
  int unsigned resp_lat = 0, wait_cnt = 0;
  bit resp_err = 0, resp_hang = 0, prev_req = 0;
  logic [31:0] last_addr;
  logic [63:0] last_wdata;
  logic last_we;
  bit exp_done = 0, exp_fail = 0;

  regbus_bridge i_regbus_bridge (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] bswap(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] resp_data(input logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  function automatic bit is_rzero(input logic [31:0] a);
    return a == 32'h0101_0C00 || a == 32'h0101_0C03 || a == 32'h0202_0007 ||
           a == 32'h0202_0009 || a == 32'h0202_000F ||
           (a >= 32'h0201_3F00 && a <= 32'h0201_3F07);
  endfunction

  function automatic bit is_wdrop(input logic [31:0] a);
    return a == 32'h000F_000F || (a >= 32'h0101_0C00 && a <= 32'h0101_0C05) ||
           a == 32'h0202_0007 || a == 32'h0202_0009 || a == 32'h0202_000F;
  endfunction

  function automatic bit goes_out(input bit we, input logic [31:0] a, input logic [3:0] sz);
    if (sz != 4'd8) return 0;
    return we ? !is_wdrop(a) : !(a == 32'h000F_000F || is_rzero(a));
  endfunction

  always @(negedge clk) begin
    if (rb_req && !prev_req) starts++;
    prev_req = rb_req;
    if (rb_ack) begin
      rb_ack = 0; rb_err = 0;
    end else if (rb_req && !resp_hang) begin
      if (wait_cnt >= resp_lat) begin
        rb_ack = 1; rb_err = resp_err; rb_rdata = resp_data(rb_addr);
        last_addr = rb_addr; last_wdata = rb_wdata; last_we = rb_we;
        bus_cnt++; wait_cnt = 0;
      end else wait_cnt++;
    end else if (!rb_req) wait_cnt = 0;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [31:0] ra, input logic [3:0] sz,
                        input logic [63:0] wd, output logic [63:0] rd);
    int guard = 0;
    host_req = 1; host_we = we; host_off = {ra, 3'b000}; host_size = sz; host_wdata = wd;
    do begin
      @(negedge clk); guard++;
    end while (!host_ack && guard < 2000);
    if (!host_ack) chk("watchdog host_ack", 0, 1);
    rd = host_rdata;
    host_req = 0;
  endtask

  task automatic clear_status();
    clr_status = 1; @(negedge clk); clr_status = 0; @(negedge clk);
    exp_done = 0; exp_fail = 0;
  endtask

  task automatic run_one(input string tag, input bit we, input logic [31:0] ra,
                         input logic [3:0] sz, input logic [63:0] wd, input bit err);
    logic [63:0] rd, exp;
    int unsigned b0 = bus_cnt;
    bit out = goes_out(we, ra, sz);
    resp_err = err;
    access(we, ra, sz, wd, rd);
    chk({tag, " R2/R3/R4/R5 bus use"}, 64'(bus_cnt - b0), out ? 1 : 0);
    exp_done = 1;
    if (sz != 4'd8 || (out && err)) exp_fail = 1;
    if (!we) begin
      if (ra == 32'h000F_000F && sz == 4'd8) exp = bswap(ID);
      else if (out && !err) exp = bswap(resp_data(ra));
      else exp = 0;
      chk({tag, " R3/R4/R7/R10 rdata"}, rd, exp);
    end
    if (out) begin
      chk({tag, " R1 addr"}, 64'(last_addr), 64'(ra));
      chk({tag, " R11 we"}, 64'(last_we), 64'(we));
      if (we) chk({tag, " R10 wdata"}, last_wdata, bswap(wd));
    end
    chk({tag, " R6/R7/R9 status"}, {status_done, status_fail}, {exp_done, exp_fail});
    resp_err = 0;
  endtask

  initial begin
    logic [63:0] rd;
    int unsigned s0, b0;
    bit dummy;
    dummy = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset status", {status_done, status_fail}, 0);
    chk("R11 reset outputs", {rb_req, host_ack}, 0);

    resp_lat = 2;
    run_one("R6 fwd read", 0, 32'h0000_1234, 8, 0, 0);
    run_one("R1 top address write", 1, 32'hFFFF_FFFF, 8, 64'h0011_2233_4455_6677, 0);
    run_one("R3 id read", 0, 32'h000F_000F, 8, 0, 0);
    run_one("R3 id write dropped", 1, 32'h000F_000F, 8, 64'hFFFF, 0);
    run_one("R3 id read after write", 0, 32'h000F_000F, 8, 0, 0);
    run_one("R4 stub last", 0, 32'h0201_3F07, 8, 0, 0);
    run_one("R4 stub neighbour", 0, 32'h0201_3F08, 8, 0, 0);
    run_one("R4 fir neighbour", 0, 32'h0101_0C01, 8, 0, 0);
    run_one("R5 drop last", 1, 32'h0101_0C05, 8, 64'h1, 0);
    run_one("R5 drop neighbour", 1, 32'h0101_0C06, 8, 64'h2, 0);
    run_one("R5 adu drop", 1, 32'h0202_0009, 8, 64'h3, 0);

    clear_status();
    chk("R9 clear", {status_done, status_fail}, 0);
    run_one("R7 error read", 0, 32'h0000_0040, 8, 0, 1);
    run_one("R7 error write", 1, 32'h0000_0048, 8, 64'h9, 1);
    run_one("R2 size 4 read", 0, 32'h0000_0050, 4, 0, 0);
    run_one("R2 size 1 write", 1, 32'h0000_0058, 1, 64'h7, 0);

    clr_status = 1;
    access(0, 32'h0000_0060, 8, 0, rd);
    chk("R9 set wins over clear", {status_done, status_fail}, 2'b10);
    clr_status = 0; @(negedge clk);
    exp_done = 0; exp_fail = 0;

    resp_lat = 200;
    run_one("R8 slow ok", 0, 32'h0000_0070, 8, 0, 0);
    resp_hang = 1;
    s0 = starts; b0 = bus_cnt;
    access(0, 32'h0000_0078, 8, 0, rd);
    chk("R8 timeout rdata", rd, 0);
    chk("R8 timeout status", {status_done, status_fail}, 2'b11);
    chk("R8 one request no ack", 64'({starts - s0, bus_cnt - b0}), 64'({32'd1, 32'd0}));
    @(negedge clk);
    chk("R8 request dropped", 64'(rb_req), 0);
    resp_hang = 0;
    exp_done = 1; exp_fail = 1;

    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra;
      logic [3:0] sz;
      case ($urandom % 8)
        0: ra = 32'h000F_000F;
        1: ra = 32'h0101_0C00 + ($urandom % 7);
        2: ra = 32'h0202_0006 + ($urandom % 10);
        3: ra = 32'h0201_3F00 + ($urandom % 9);
        default: ra = $urandom;
      endcase
      sz = ($urandom % 10 == 0) ? 4'($urandom % 8) : 4'd8;
      resp_lat = $urandom % 6;
      if ($urandom % 16 == 0) clear_status();
      run_one("random", 1'($urandom % 2), ra, sz, {$urandom, $urandom}, ($urandom % 8) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule